// File: doc/BRIEF.md
# Compare-Clear Interval Timer / Event Counter

This block is a single timer channel built around one up-counter. The counter advances on count ticks. A tick comes either from a free-running prescaler, which offers five power-of-two divide ratios, or from edges detected on an external event pin. With the external source the channel works as an event counter.

A compare value is checked against the counter on every tick. When the counter reaches the compare value, the channel emits a one-cycle interrupt pulse and a one-cycle trigger pulse. The counter is then zeroed on the following tick, so the channel repeats with a period of (compare + 1) ticks. Software can force a restart through a request input. A sticky flag records counter wraparound until a clear input drops it.

All control fields are plain level inputs, sampled every cycle. The block has no streaming data path, so no valid/ready handshake appears. The interrupt and trigger outputs are pulses that need no acknowledge, and the count is a plain status bus.

Top module: `ivt_timer`

## Requirements
- R1: After reset, the count is 0, the interrupt and trigger outputs are 0, and the overflow flag is 0.
- R2: Select codes 0, 1, 2, 3 and 4 give one tick every 2, 4, 8, 16 and 32 clock cycles. Codes 5 to 14 produce no ticks.
- R3: Select code 15 takes ticks from the external event pin, after a two-flop synchronizer. Edge code 0 counts falling edges, 1 counts rising edges, 3 counts both edges, and 2 counts nothing.
- R4: A tick that makes the count equal to the compare value drives both the interrupt and the trigger high for exactly one cycle. The count shows the compare value in that cycle.
- R5: The tick after a match zeroes the counter instead of advancing it. The match period is therefore (compare + 1) ticks.
- R6: A tick that wraps the counter from all-ones to 0 sets the overflow flag. The flag stays set until a cycle with the clear input high. If a wrap and a clear fall in the same cycle, the wrap wins.
- R7: A restart request is held until the next tick, and that tick zeroes the counter. A request made while counting is disabled is dropped.
- R8: With a compare value of 0, the wrap to 0 raises the interrupt. The zeroing tick that follows gives no interrupt, and counting then resumes from 1.
- R9: While enable is 0, the count is held at 0 and no interrupt, trigger or pending clear is produced.
- R10: A restart request and a pending compare clear that are consumed on the same tick give a single clear. The next tick counts to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| src_sel | input | 4 | Tick source: 0-4 prescaler taps, 15 external pin |
| edge_mode | input | 2 | External edge: 0 fall, 1 rise, 2 none, 3 both |
| evt_in | input | 1 | Asynchronous external event pin |
| cmp_val | input | CNT_W | Compare value |
| sw_restart | input | 1 | One-cycle restart request |
| ovf_clr | input | 1 | Overflow flag clear |
| count | output | CNT_W | Current counter value |
| cmp_irq | output | 1 | Compare interrupt pulse |
| cmp_trig | output | 1 | Compare trigger pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench measures the cycle distance between interrupt pulses for every prescaler tap. A design that cleared the counter on the match itself would give periods one tick short, and a wrong tap would scale the period. Edge modes are driven by counted pulses on the event pin, so a swapped edge decode or a reserved code that counts would show up as a wrong event total.

With a compare value of 0, the bench checks the wrap interrupt, the silent zeroing tick and the resume at 1. A design that fired on every zero would report an extra interrupt. The bench also checks a restart that coincides with a compare clear. A design that applied both clears in sequence would show a count of 0 where 1 is due, and a design that kept a request made while disabled would lose the first counted event.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned TAP_N  = 5;
  localparam logic [3:0]  SRC_EXT = 4'hF;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int unsigned TAPS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TAPS-1:0] tap_o
);
  logic [TAPS-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // tap k strobes once every 2^(k+1) cycles
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap_o[k] = &div_q[k:0];
  end

  // R2
  tap0_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_o[0] |=> !tap_o[0]);
endmodule

// File: rtl/ivt_event_sync.sv
module ivt_event_sync
  import ivt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_i,
  input  edge_mode_e mode_i,
  output logic       strobe_o
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= evt_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  always_comb begin
    unique case (mode_i)
      EDGE_FALL: strobe_o = fall;
      EDGE_RISE: strobe_o = rise;
      EDGE_BOTH: strobe_o = rise | fall;
      default:   strobe_o = 1'b0;
    endcase
  end

  // R3
  edge_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s2_q) |-> $past(s1_q));
endmodule

// File: rtl/ivt_count_core.sv
module ivt_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             sw_req_i,
  input  logic             ovf_clr_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             trig_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic cmp_pend_q, sw_pend_q, irq_q, trig_q, ovf_q;
  logic do_clear, hit, wrap;

  always_comb begin
    do_clear = cmp_pend_q | sw_pend_q | sw_req_i;
    cnt_nxt  = do_clear ? '0 : cnt_q + 1'b1;
    wrap     = !do_clear && (&cnt_q);
    hit      = !do_clear && (cnt_nxt == cmp_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      cmp_pend_q <= 1'b0;
      sw_pend_q  <= 1'b0;
      irq_q      <= 1'b0;
      trig_q     <= 1'b0;
    end else if (!en_i) begin
      cnt_q      <= '0;
      cmp_pend_q <= 1'b0;
      sw_pend_q  <= 1'b0;
      irq_q      <= 1'b0;
      trig_q     <= 1'b0;
    end else if (tick_i) begin
      cnt_q      <= cnt_nxt;
      cmp_pend_q <= hit;
      sw_pend_q  <= 1'b0;
      irq_q      <= hit;
      trig_q     <= hit;
    end else begin
      if (sw_req_i) sw_pend_q <= 1'b1;
      irq_q  <= 1'b0;
      trig_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovf_q <= 1'b0;
    else if (en_i && tick_i && wrap) ovf_q <= 1'b1;
    else if (ovf_clr_i)              ovf_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;
  assign trig_o = trig_q;
  assign ovf_o  = ovf_q;

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R4
  irq_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == $past(cmp_i)));
  // R5
  clear_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && cmp_pend_q) |=> (cnt_q == '0));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
  // R7
  sw_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !sw_pend_q);
  // R9
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0 && !irq_q && !trig_q));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [3:0]       src_sel,
  input  logic [1:0]       edge_mode,
  input  logic             evt_in,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             sw_restart,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             cmp_irq,
  output logic             cmp_trig,
  output logic             ovf_flag
);
  logic [TAP_N-1:0] taps;
  logic             evt_strobe;
  logic             tick;

  ivt_prescaler #(.TAPS(TAP_N)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tap_o (taps)
  );

  ivt_event_sync u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_in),
    .mode_i   (edge_mode_e'(edge_mode)),
    .strobe_o (evt_strobe)
  );

  always_comb begin
    tick = 1'b0;
    if (src_sel == SRC_EXT) tick = evt_strobe;
    for (int k = 0; k < TAP_N; k++) begin
      if (src_sel == 4'(k)) tick = taps[k];
    end
  end

  ivt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (cnt_en),
    .tick_i    (tick),
    .sw_req_i  (sw_restart),
    .ovf_clr_i (ovf_clr),
    .cmp_i     (cmp_val),
    .cnt_o     (count),
    .irq_o     (cmp_irq),
    .trig_o    (cmp_trig),
    .ovf_o     (ovf_flag)
  );

  // R4
  irq_trig_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> cmp_trig);
endmodule

// File: tb/ivt_timer_bench.sv
`timescale 1ns/1ps
module ivt_timer_bench;
  localparam int BW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 1'b0, evt_in = 1'b0, sw_restart = 1'b0, ovf_clr = 1'b0;
  logic [3:0] src_sel = 4'd0;
  logic [1:0] edge_mode = 2'd1;
  logic [BW-1:0] cmp_val = '0;
  logic [BW-1:0] count;
  logic cmp_irq, cmp_trig, ovf_flag;

  ivt_timer #(.CNT_W(BW)) u_ivt_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .src_sel(src_sel),
    .edge_mode(edge_mode), .evt_in(evt_in), .cmp_val(cmp_val),
    .sw_restart(sw_restart), .ovf_clr(ovf_clr), .count(count),
    .cmp_irq(cmp_irq), .cmp_trig(cmp_trig), .ovf_flag(ovf_flag)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int irq_seen = 0, irq_cyc = 0, irq_val = 0, bad_pair = 0, bad_width = 0;
  logic irq_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmp_irq) begin
      irq_seen <= irq_seen + 1;
      irq_cyc  <= cyc;
      irq_val  <= int'(count);
    end
    if (cmp_irq != cmp_trig) bad_pair <= bad_pair + 1;
    if (cmp_irq && irq_prev) bad_width <= bad_width + 1;
    irq_prev <= cmp_irq;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic evt_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      evt_in = 1'b1; step(4);
      evt_in = 1'b0; step(4);
    end
    step(4);
  endtask

  task automatic restart_ch(input logic [3:0] s, input logic [1:0] e, input int c);
    cnt_en = 1'b0; step(1);
    src_sel = s; edge_mode = e; cmp_val = BW'(c);
    cnt_en = 1'b1;
  endtask

  task automatic wait_irq();
    int c0 = irq_seen;
    while (irq_seen == c0) step(1);
  endtask

  // {select, compare, expected period in cycles}
  localparam logic [27:0] VEC [0:5] = '{
    {4'd0, 8'd3, 16'd8},
    {4'd1, 8'd2, 16'd12},
    {4'd2, 8'd1, 16'd16},
    {4'd3, 8'd4, 16'd80},
    {4'd4, 8'd2, 16'd96},
    {4'd0, 8'd7, 16'd16}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t0, s0;
    step(3); rst_n = 1'b1; step(1);
    // R1
    chk("R1 count", int'(count), 0);
    chk("R1 irq", int'(cmp_irq) + int'(cmp_trig), 0);
    chk("R1 ovf", int'(ovf_flag), 0);

    // R9: disabled channel stays at zero
    src_sel = 4'd0; cmp_val = 8'd1; s0 = irq_seen; step(40);
    chk("R9 count held", int'(count), 0);
    chk("R9 no irq", irq_seen - s0, 0);

    // R2 / R5: periods per tap, walked from the table
    for (int v = 0; v < 6; v++) begin
      restart_ch(VEC[v][27:24], 2'd1, int'(VEC[v][23:16]));
      wait_irq(); t0 = irq_cyc;
      wait_irq();
      chk("R2 R5 period", irq_cyc - t0, int'(VEC[v][15:0]));
      chk("R4 count at irq", irq_val, int'(VEC[v][23:16]));
    end

    // R2: unused select code gives no ticks
    restart_ch(4'd5, 2'd1, 1); step(100);
    chk("R2 unused code", int'(count), 0);

    // R3: edge modes, 6 pulses each
    restart_ch(4'hF, 2'd1, 200); evt_pulse(6); chk("R3 rising", int'(count), 6);
    restart_ch(4'hF, 2'd0, 200); evt_pulse(6); chk("R3 falling", int'(count), 6);
    restart_ch(4'hF, 2'd3, 200); evt_pulse(6); chk("R3 both", int'(count), 12);
    restart_ch(4'hF, 2'd2, 200); evt_pulse(6); chk("R3 reserved", int'(count), 0);

    // R5: clear waits for the next tick
    restart_ch(4'hF, 2'd1, 3); s0 = irq_seen; evt_pulse(3);
    chk("R5 holds match", int'(count), 3);
    chk("R4 one irq", irq_seen - s0, 1);
    evt_pulse(1); chk("R5 cleared", int'(count), 0);
    evt_pulse(1); chk("R5 resumes", int'(count), 1);

    // R7: restart held until next tick
    restart_ch(4'hF, 2'd1, 200); evt_pulse(5);
    sw_restart = 1'b1; step(1); sw_restart = 1'b0; step(3);
    chk("R7 pending", int'(count), 5);
    evt_pulse(1); chk("R7 cleared", int'(count), 0);
    evt_pulse(1); chk("R7 resumes", int'(count), 1);

    // R7: request while disabled is dropped
    cnt_en = 1'b0; step(1);
    sw_restart = 1'b1; step(1); sw_restart = 1'b0; step(1);
    cnt_en = 1'b1; evt_pulse(3);
    chk("R7 dropped", int'(count), 3);

    // R10: restart coinciding with compare clear
    restart_ch(4'hF, 2'd1, 3); evt_pulse(3);
    sw_restart = 1'b1; step(1); sw_restart = 1'b0;
    evt_pulse(1); chk("R10 clear", int'(count), 0);
    evt_pulse(1); chk("R10 single", int'(count), 1);

    // R8 / R6: compare zero on wraparound
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    restart_ch(4'hF, 2'd1, 0); s0 = irq_seen;
    evt_pulse(255);
    chk("R6 before wrap", int'(ovf_flag), 0);
    chk("R8 no early irq", irq_seen - s0, 0);
    evt_pulse(1);
    chk("R8 wrap count", int'(count), 0);
    chk("R8 wrap irq", irq_seen - s0, 1);
    chk("R6 set", int'(ovf_flag), 1);
    evt_pulse(1);
    chk("R8 silent clear", irq_seen - s0, 1);
    chk("R8 count zero", int'(count), 0);
    evt_pulse(1); chk("R8 resumes", int'(count), 1);
    chk("R6 sticky", int'(ovf_flag), 1);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0; step(1);
    chk("R6 cleared", int'(ovf_flag), 0);

    // R4: pulse shape over the whole run
    chk("R4 irq/trig pair", bad_pair, 0);
    chk("R4 one cycle", bad_width, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule